// File: doc/BRIEF.md
# Key-Gated Three-Candidate Polling Session Controller

This block sequences one polling session for three candidates. An officer arms the controller with the rearm button. Voting opens only when the officer presses the start/stop button while the 16 key switches hold the secret value. While the poll is open, voters press one of three candidate buttons. Each accepted press adds one to that candidate's count and to a running total, and the total is on an output at all times.

The poll closes on its own when the total reaches the cap of 99. The officer can also close it early with the same keyed start/stop action. After closing, the block publishes the winning candidate number, or 0 when the highest count is shared. The winner stays hidden until the session has ended.

Two free-running clock-enable dividers pace the block. The slow tick samples the candidate buttons, so holding a button adds only one vote. The fast tick toggles a pair of LEDs in alternation while voting is open. All results leave the block as binary values; display decoding happens elsewhere.

Top module: `vote_session_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, the block is idle, total and winner are 0, `winner_valid` is low, and both LED outputs are off.
- R2: In idle, a rising edge on `rearm_btn` moves the block to the armed state. The start/stop button and the candidate buttons have no effect in idle.
- R3: In the armed state, a rising edge on `officer_btn` while `key_sw` equals the parameter `KEY` opens voting, and `key_ok_led` lights in the same cycle. A wrong key or no press leaves the block armed with `key_ok_led` off. `key_ok_led` stays lit from the opening of the poll until the return to idle.
- R4: While voting is open, on each slow tick a one-hot `cand_btn` value adds one vote to that candidate (bit 0 is candidate 1, bit 2 is candidate 3) and one to the total. The bit must have been low at the previous slow tick, so a held button counts once. A value with two or more bits set counts nothing.
- R5: Candidate presses outside the voting state leave the total unchanged.
- R6: The total never exceeds 99. One cycle after the total reaches 99, the block closes the poll, and one cycle later it shows the winner.
- R7: While voting is open, a keyed rising edge on `officer_btn` force-stops the poll and leads to the winner display. A press with a wrong key is ignored.
- R8: `winner` is 1, 2 or 3 for the candidate that holds a strict maximum count, and 0 when two or more candidates share the top count. It is qualified by `winner_valid`, which is high only in the display state. Outside that state `winner` reads 0.
- R9: In the display state, only a rising edge on `rearm_btn` has an effect. It returns the block to idle and clears all counts and the winner. The start/stop button is ignored there.
- R10: While voting is open, `flash_leds` reads 2'b01 or 2'b10 and inverts on each fast tick. In every other state it reads 2'b00.
- R11: `session_state` encodes idle=0, armed=1, voting=2, closing=3, display=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rearm_btn | input | 1 | Arms the block from idle; returns it to idle from display |
| officer_btn | input | 1 | Keyed start/stop of the poll |
| key_sw | input | 16 | Switch code compared with `KEY` |
| cand_btn | input | 3 | Candidate buttons, bit i = candidate i+1 |
| total_votes | output | 7 | Running total of accepted votes |
| winner | output | 2 | Winning candidate number, 0 for a tie |
| winner_valid | output | 1 | High while the winner is shown |
| key_ok_led | output | 1 | Key accepted indicator |
| flash_leds | output | 2 | Alternating activity LEDs |
| session_state | output | 3 | Current session state code |

## Verification
The bound checker watches the following on every cycle:
- the total stays at or below the cap and moves by at most one per cycle while voting;
- the total is frozen in idle, armed and closing;
- a wrong key cannot leave the armed state;
- only the rearm edge leaves the display state;
- the winner stays hidden outside the display state;
- the flash LEDs are dark once voting stops.

Other behaviours can only be shown by the bench's scenarios:
- that a held button counts once and a two-button press counts nothing;
- that the published winner matches the vote counts, with ties giving 0;
- that a full run of 99 votes closes the poll by itself.

// File: rtl/vote_pkg.sv
package vote_pkg;
  localparam int NCAND = 3;
  localparam int WIN_W = $clog2(NCAND + 1);

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ARMED  = 3'd1,
    ST_VOTING = 3'd2,
    ST_CLOSED = 3'd3,
    ST_SHOW   = 3'd4
  } sess_state_t;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/vote_tally.sv
module vote_tally #(
  parameter int NCAND    = 3,
  parameter int VOTE_CAP = 99,
  parameter int CNT_W    = 7
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clear,
  input  logic                        enable,
  input  logic                        slow_tick,
  input  logic [NCAND-1:0]            cand,
  output logic [NCAND-1:0][CNT_W-1:0] counts,
  output logic [CNT_W-1:0]            total
);
  localparam logic [CNT_W-1:0] CAP_V = CNT_W'(VOTE_CAP);

  logic [NCAND-1:0] seen_q;
  logic [NCAND-1:0] fresh;
  logic             accept;

  // a press is fresh when its bit was low at the previous slow tick
  assign fresh  = cand & ~seen_q;
  assign accept = enable && slow_tick && $onehot(cand) && (|fresh) && (total < CAP_V);

  always_ff @(posedge clk) begin
    if (rst) seen_q <= '0;
    else if (slow_tick) seen_q <= cand;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) total <= '0;
    else if (accept) total <= total + 1'b1;
  end

  for (genvar i = 0; i < NCAND; i++) begin : g_cand
    always_ff @(posedge clk) begin
      if (rst || clear) counts[i] <= '0;
      else if (accept && cand[i]) counts[i] <= counts[i] + 1'b1;
    end
  end
endmodule

// File: rtl/winner_pick.sv
module winner_pick #(
  parameter int NCAND = 3,
  parameter int CNT_W = 7,
  parameter int WIN_W = 2
) (
  input  logic [NCAND-1:0][CNT_W-1:0] counts,
  output logic [WIN_W-1:0]            winner
);
  logic [CNT_W-1:0] best;
  int               best_idx;
  int               holders;

  always_comb begin
    best     = '0;
    best_idx = 0;
    holders  = 0;
    for (int i = 0; i < NCAND; i++) begin
      if (counts[i] > best) best = counts[i];
    end
    for (int i = 0; i < NCAND; i++) begin
      if (counts[i] == best) begin
        holders  = holders + 1;
        best_idx = i;
      end
    end
    winner = (holders == 1) ? WIN_W'(best_idx + 1) : '0;
  end
endmodule

// File: rtl/session_fsm.sv
module session_fsm
  import vote_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rearm,
  input  logic        cmd,
  input  logic        key_match,
  input  logic        at_cap,
  output sess_state_t state_q,
  output sess_state_t state_d
);
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (rearm) state_d = ST_ARMED;
      ST_ARMED:  if (cmd && key_match) state_d = ST_VOTING;
      ST_VOTING: if ((cmd && key_match) || at_cap) state_d = ST_CLOSED;
      ST_CLOSED: state_d = ST_SHOW;
      ST_SHOW:   if (rearm) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else state_q <= state_d;
  end
endmodule

// File: rtl/vote_session_ctrl.sv
module vote_session_ctrl
  import vote_pkg::*;
#(
  parameter logic [15:0] KEY      = 16'hC3A5,
  parameter int          VOTE_CAP = 99,
  parameter int          SLOW_DIV = 100_000_000,
  parameter int          FAST_DIV = 50_000_000,
  parameter int          CNT_W    = $clog2(VOTE_CAP + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rearm_btn,
  input  logic             officer_btn,
  input  logic [15:0]      key_sw,
  input  logic [2:0]       cand_btn,
  output logic [CNT_W-1:0] total_votes,
  output logic [1:0]       winner,
  output logic             winner_valid,
  output logic             key_ok_led,
  output logic [1:0]       flash_leds,
  output logic [2:0]       session_state
);
  localparam logic [CNT_W-1:0] CAP_V = CNT_W'(VOTE_CAP);

  logic                        slow_tick, fast_tick;
  logic                        officer_q, rearm_q;
  logic                        cmd, rearm;
  logic                        key_match;
  sess_state_t                 state_q, state_d;
  logic [NCAND-1:0][CNT_W-1:0] counts;
  logic [WIN_W-1:0]            pick;

  tick_divider #(.DIV(SLOW_DIV)) u_slow (.clk(clk), .rst(rst), .tick(slow_tick));
  tick_divider #(.DIV(FAST_DIV)) u_fast (.clk(clk), .rst(rst), .tick(fast_tick));

  // rising-edge detection on the officer and rearm buttons
  always_ff @(posedge clk) begin
    if (rst) begin
      officer_q <= 1'b0;
      rearm_q   <= 1'b0;
    end else begin
      officer_q <= officer_btn;
      rearm_q   <= rearm_btn;
    end
  end

  assign cmd       = officer_btn & ~officer_q;
  assign rearm     = rearm_btn & ~rearm_q;
  assign key_match = (key_sw == KEY);

  session_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .rearm    (rearm),
    .cmd      (cmd),
    .key_match(key_match),
    .at_cap   (total_votes >= CAP_V),
    .state_q  (state_q),
    .state_d  (state_d)
  );

  vote_tally #(.NCAND(NCAND), .VOTE_CAP(VOTE_CAP), .CNT_W(CNT_W)) u_tally (
    .clk      (clk),
    .rst      (rst),
    .clear    ((state_q == ST_SHOW) && rearm),
    .enable   (state_q == ST_VOTING),
    .slow_tick(slow_tick),
    .cand     (cand_btn),
    .counts   (counts),
    .total    (total_votes)
  );

  winner_pick #(.NCAND(NCAND), .CNT_W(CNT_W), .WIN_W(WIN_W)) u_pick (
    .counts(counts),
    .winner(pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      winner       <= '0;
      winner_valid <= 1'b0;
    end else if (state_q == ST_CLOSED) begin
      winner       <= pick;
      winner_valid <= 1'b1;
    end else if (state_d != ST_SHOW) begin
      winner       <= '0;
      winner_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) key_ok_led <= 1'b0;
    else key_ok_led <= (state_d == ST_VOTING) || (state_d == ST_CLOSED) || (state_d == ST_SHOW);
  end

  always_ff @(posedge clk) begin
    if (rst) flash_leds <= 2'b00;
    else if (state_q != ST_VOTING) flash_leds <= 2'b00;
    else if (flash_leds == 2'b00) flash_leds <= 2'b01;
    else if (fast_tick) flash_leds <= ~flash_leds;
  end

  assign session_state = state_q;
endmodule

// File: rtl/vote_session_chk.sv
module vote_session_chk
  import vote_pkg::*;
#(
  parameter logic [15:0] KEY      = 16'hC3A5,
  parameter int          VOTE_CAP = 99,
  parameter int          CNT_W    = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             rearm_btn,
  input logic [15:0]      key_sw,
  input logic [CNT_W-1:0] total_votes,
  input logic [1:0]       winner,
  input logic             winner_valid,
  input logic             key_ok_led,
  input logic [1:0]       flash_leds,
  input logic [2:0]       session_state
);
  // R6
  total_cap_chk: assert property (@(posedge clk) disable iff (rst)
    int'(total_votes) <= VOTE_CAP);

  // R6
  cap_close_chk: assert property (@(posedge clk) disable iff (rst)
    (session_state == ST_VOTING && int'(total_votes) == VOTE_CAP) |=> session_state == ST_CLOSED);

  // R4
  vote_step_chk: assert property (@(posedge clk) disable iff (rst)
    session_state == ST_VOTING |=>
      (total_votes == $past(total_votes)) || (total_votes == $past(total_votes) + 1'b1));

  // R5
  quiet_total_chk: assert property (@(posedge clk) disable iff (rst)
    (session_state == ST_IDLE || session_state == ST_ARMED || session_state == ST_CLOSED)
      |=> $stable(total_votes));

  // R3
  wrong_key_chk: assert property (@(posedge clk) disable iff (rst)
    (session_state == ST_ARMED && key_sw != KEY) |=> session_state == ST_ARMED);

  // R3
  key_led_chk: assert property (@(posedge clk) disable iff (rst)
    key_ok_led == (session_state == ST_VOTING || session_state == ST_CLOSED || session_state == ST_SHOW));

  // R9
  show_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (session_state == ST_SHOW && !rearm_btn) |=> session_state == ST_SHOW);

  // R8
  win_hidden_chk: assert property (@(posedge clk) disable iff (rst)
    winner_valid |-> session_state == ST_SHOW);

  // R8
  win_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !winner_valid |-> winner == 2'd0);

  // R10
  flash_off_chk: assert property (@(posedge clk) disable iff (rst)
    session_state != ST_VOTING |=> flash_leds == 2'b00);
endmodule

bind vote_session_ctrl vote_session_chk #(.KEY(KEY), .VOTE_CAP(VOTE_CAP), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rearm_btn    (rearm_btn),
  .key_sw       (key_sw),
  .total_votes  (total_votes),
  .winner       (winner),
  .winner_valid (winner_valid),
  .key_ok_led   (key_ok_led),
  .flash_leds   (flash_leds),
  .session_state(session_state)
);

// File: tb/vote_session_ctrl_tb.sv
`timescale 1ns/1ps
module vote_session_ctrl_tb;
  localparam logic [15:0] KEY  = 16'h5A3C;
  localparam int          CAP  = 99;
  localparam int          SDIV = 8;
  localparam int          FDIV = 3;
  localparam int          CW   = $clog2(CAP + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rearm_btn = 1'b0;
  logic          officer_btn = 1'b0;
  logic [15:0]   key_sw = 16'h0000;
  logic [2:0]    cand_btn = 3'b000;
  logic [CW-1:0] total_votes;
  logic [1:0]    winner;
  logic          winner_valid;
  logic          key_ok_led;
  logic [1:0]    flash_leds;
  logic [2:0]    session_state;

  int checks = 0;
  int errors = 0;
  int model [3];
  int model_total;

  always #2 clk = ~clk;

  vote_session_ctrl #(.KEY(KEY), .VOTE_CAP(CAP), .SLOW_DIV(SDIV), .FAST_DIV(FDIV)) u_dut (
    .clk(clk), .rst(rst), .rearm_btn(rearm_btn), .officer_btn(officer_btn),
    .key_sw(key_sw), .cand_btn(cand_btn), .total_votes(total_votes),
    .winner(winner), .winner_valid(winner_valid), .key_ok_led(key_ok_led),
    .flash_leds(flash_leds), .session_state(session_state)
  );

  function automatic int expect_winner(int a, int b, int c);
    int best = a;
    int n = 0;
    int idx = 0;
    if (b > best) best = b;
    if (c > best) best = c;
    if (a == best) begin n++; idx = 1; end
    if (b == best) begin n++; idx = 2; end
    if (c == best) begin n++; idx = 3; end
    return (n == 1) ? idx : 0;
  endfunction

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_officer(logic [15:0] k);
    @(negedge clk);
    key_sw = k;
    officer_btn = 1'b1;
    wait_cycles(3);
    officer_btn = 1'b0;
    wait_cycles(3);
  endtask

  task automatic pulse_rearm();
    @(negedge clk);
    rearm_btn = 1'b1;
    wait_cycles(3);
    rearm_btn = 1'b0;
    wait_cycles(3);
  endtask

  // hold a button pattern, release it, then update the model for a valid single press
  task automatic press(logic [2:0] b, int hold, bit counts_it);
    @(negedge clk);
    cand_btn = b;
    wait_cycles(hold);
    cand_btn = 3'b000;
    wait_cycles(SDIV + 3);
    if (counts_it && model_total < CAP && $countones(b) == 1) begin
      for (int i = 0; i < 3; i++) if (b[i]) model[i]++;
      model_total++;
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 3; i++) model[i] = 0;
    model_total = 0;
  endtask

  task automatic open_poll();
    pulse_rearm();
    pulse_officer(KEY);
    clear_model();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int flips;
    logic [1:0] last_flash;
    void'($urandom(32'd2024));
    clear_model();
    wait_cycles(5);
    rst = 1'b0;
    wait_cycles(2);

    // R1 reset state
    check_eq("R1 state", session_state, 0);
    check_eq("R1 total", total_votes, 0);
    check_eq("R1 winner", winner, 0);
    check_eq("R1 valid", winner_valid, 0);
    check_eq("R1 keyled", key_ok_led, 0);
    check_eq("R1 flash", flash_leds, 0);

    // R5 presses in idle ignored; R2 officer ignored in idle
    press(3'b001, SDIV + 3, 1'b0);
    check_eq("R5 idle press", total_votes, 0);
    pulse_officer(KEY);
    check_eq("R2 officer in idle", session_state, 0);

    // R2 arm
    pulse_rearm();
    check_eq("R2 armed", session_state, 1);

    // R3 wrong key
    pulse_officer(KEY ^ 16'h0100);
    check_eq("R3 wrong key state", session_state, 1);
    check_eq("R3 wrong key led", key_ok_led, 0);
    press(3'b010, SDIV + 3, 1'b0);
    check_eq("R5 armed press", total_votes, 0);

    // R3 correct key, R11 voting code
    pulse_officer(KEY);
    check_eq("R3 R11 voting state", session_state, 2);
    check_eq("R3 keyled", key_ok_led, 1);

    // R10 flashing alternation
    flips = 0;
    last_flash = flash_leds;
    for (int i = 0; i < 4 * FDIV; i++) begin
      @(negedge clk);
      if (flash_leds != 2'b01 && flash_leds != 2'b10) check_eq("R10 flash pattern", flash_leds, 1);
      if (flash_leds != last_flash) flips++;
      last_flash = flash_leds;
    end
    check_eq("R10 flash toggles", (flips >= 2) ? 1 : 0, 1);

    // R4 held press counts once
    press(3'b001, 3 * SDIV, 1'b1);
    check_eq("R4 held press", total_votes, 1);
    // R4 two buttons at once ignored
    press(3'b011, SDIV + 3, 1'b0);
    check_eq("R4 multi press", total_votes, 1);

    // R7 wrong-key stop ignored
    pulse_officer(16'h0000);
    check_eq("R7 wrong stop", session_state, 2);

    // R4 random votes
    for (int n = 0; n < 20; n++) begin
      int c = int'($urandom_range(0, 2));
      press(3'b001 << c, SDIV + 3 + int'($urandom_range(0, 10)), 1'b1);
      if (total_votes != model_total) check_eq("R4 random total", total_votes, model_total);
    end
    check_eq("R4 total after random", total_votes, model_total);
    check_eq("R8 hidden during vote", winner_valid, 0);

    // R7 force stop and R8 winner
    pulse_officer(KEY);
    check_eq("R7 R11 show state", session_state, 4);
    check_eq("R8 valid", winner_valid, 1);
    check_eq("R8 winner", winner, expect_winner(model[0], model[1], model[2]));

    // R5 R9 inputs ignored in display
    press(3'b100, SDIV + 3, 1'b0);
    check_eq("R5 show press", total_votes, model_total);
    pulse_officer(KEY);
    check_eq("R9 officer in show", session_state, 4);

    // R9 rearm returns to idle, clears
    pulse_rearm();
    check_eq("R9 idle", session_state, 0);
    check_eq("R9 total cleared", total_votes, 0);
    check_eq("R9 winner cleared", winner_valid, 0);
    check_eq("R9 keyled off", key_ok_led, 0);

    // R8 tie gives 0
    open_poll();
    press(3'b001, SDIV + 3, 1'b1);
    press(3'b010, SDIV + 3, 1'b1);
    press(3'b010, SDIV + 3, 1'b1);
    press(3'b001, SDIV + 3, 1'b1);
    pulse_officer(KEY);
    check_eq("R8 tie winner", winner, 0);
    check_eq("R8 tie valid", winner_valid, 1);
    pulse_rearm();

    // R8 candidate three wins
    open_poll();
    press(3'b100, SDIV + 3, 1'b1);
    press(3'b001, SDIV + 3, 1'b1);
    press(3'b100, SDIV + 3, 1'b1);
    pulse_officer(KEY);
    check_eq("R8 cand3 winner", winner, 3);
    pulse_rearm();

    // R6 cap closes the poll
    open_poll();
    while (model_total < CAP) begin
      int c = int'($urandom_range(0, 2));
      press(3'b001 << c, SDIV + 3, 1'b1);
    end
    check_eq("R6 total at cap", total_votes, CAP);
    check_eq("R6 auto close", session_state, 4);
    check_eq("R8 cap winner", winner, expect_winner(model[0], model[1], model[2]));
    press(3'b010, SDIV + 3, 1'b0);
    check_eq("R6 no overrun", total_votes, CAP);
    check_eq("R10 flash off", flash_leds, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule